// File: doc/BRIEF.md
# Selectable Crystal Reference Divider

This block turns a 4 MHz crystal-derived system clock into the two comparison rates that a frequency synthesizer loop uses. It gives two enables. The fast one paces a digital phase/frequency detector. The slow one is 32 times rarer and paces a sample-and-hold style comparison. Both outputs are one-clock-wide enable pulses in the system clock domain. They are not derived clocks.

A single select input picks one of two raster families. With select low the fast divider counts 125 clocks, which gives 32 kHz fast and 1 kHz slow. With select high it counts 100 clocks, which gives 40 kHz fast and 1.25 kHz slow. After a divide-by-10 prescaler on the FM path, these rates give tuning steps of 1 kHz or 1.25 kHz on AM, and 10 kHz or 12.5 kHz on FM. The select is sampled only at the end of a fast period, so a change never produces a short or stretched period. The slow enable is cascaded from the fast one, so the two stay aligned.

The fast stage is a two-state machine:
- FP_COUNT advances the counter.
- The transition FP_COUNT to FP_TERMINAL is taken when the counter reaches its ratio minus two.
- FP_TERMINAL lasts one cycle and raises the fast enable.
- The transition FP_TERMINAL to FP_COUNT clears the counter and latches the select.

The slow stage has two states:
- SP_GATHER counts fast enables.
- The transition SP_GATHER to SP_FINAL is taken on the 31st fast enable.
- In SP_FINAL the next fast enable also raises the slow enable.
- That enable takes the transition SP_FINAL to SP_GATHER, which clears the count.

A synchronous reset puts both stages in their first state with zero counts. It also latches the select.

Top module: `xtal_ref_divider`

## Requirements
- R1: While rst is sampled high, and in the cycle after any rising edge that samples rst high, ref_fast and ref_slow are both low.
- R2: With raster_sel held at 0, ref_fast pulses exactly every 125 clock cycles (32 kHz from 4 MHz).
- R3: With raster_sel held at 1, ref_fast pulses exactly every 100 clock cycles (40 kHz from 4 MHz).
- R4: Each ref_fast pulse is one clock cycle wide. ref_fast is never high in two consecutive cycles.
- R5: ref_slow is high only in a cycle where ref_fast is high. It is high on every 32nd ref_fast pulse, counted from reset.
- R6: raster_sel is sampled only in the cycle where ref_fast is high (and at reset). The period in progress keeps its length, and a select that toggles and returns inside a period has no effect.
- R7: After reset, the first ref_fast pulse is high during the cycle that follows the N-th rising edge, counted from the last edge that samples rst high (that edge included). N is 125 or 100, chosen by raster_sel at that edge.
- R8: With raster_sel held, consecutive ref_slow pulses are exactly 32*N clock cycles apart (4000 or 3200).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived system clock (4 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| raster_sel | input | 1 | Raster choice: 0 divides by 125, 1 divides by 100 |
| ref_fast | output | 1 | One-cycle enable at the fast comparison rate |
| ref_slow | output | 1 | One-cycle enable at 1/32 of the fast rate |

## Verification
The bound checker tests several properties on every cycle:
- Pulse width.
- The slow enable falling inside a fast enable.
- Both outputs being low after a reset edge.
- Every fast period being one of the two legal lengths.
- The slow enable landing on exactly every 32nd fast enable.

Some behaviour only the bench's scenarios can show:
- The exact first-pulse timing after reset.
- That a select change mid-period leaves the running period untouched.
- That a select glitch which returns before the terminal count is ignored.
- The full slow spacing under each raster.

A behavioural model in the bench gives the expected output for every cycle.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Raster family chosen by the select input.
    typedef enum logic {
        RASTER_NARROW = 1'b0,   // divide by the coarse ratio, 32 kHz fast tick
        RASTER_WIDE   = 1'b1    // divide by the fine ratio, 40 kHz fast tick
    } raster_e;

    // Phases of the fast divider.
    typedef enum logic {
        FP_COUNT    = 1'b0,
        FP_TERMINAL = 1'b1
    } fast_phase_e;

    // Phases of the cascaded slow divider.
    typedef enum logic {
        SP_GATHER = 1'b0,
        SP_FINAL  = 1'b1
    } slow_phase_e;

    function automatic raster_e decode_raster(input logic sel);
        return sel ? RASTER_WIDE : RASTER_NARROW;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refdiv_fast_stage.sv
module refdiv_fast_stage
    import refdiv_pkg::*;
#(
    parameter int unsigned DIV_NARROW = 125,
    parameter int unsigned DIV_WIDE   = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic raster_sel,
    output logic tick
);

    localparam int unsigned DIV_MAX = max_u(DIV_NARROW, DIV_WIDE);
    localparam int unsigned CNT_W   = $clog2(DIV_MAX);

    // The state machine leaves FP_COUNT one count before the last one,
    // so the terminal phase holds the final count of the period.
    localparam logic [CNT_W-1:0] PRE_NARROW = CNT_W'(DIV_NARROW - 2);
    localparam logic [CNT_W-1:0] PRE_WIDE   = CNT_W'(DIV_WIDE - 2);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    fast_phase_e      ph_q,  ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    raster_e          ras_q, ras_d;

    function automatic logic [CNT_W-1:0] pre_terminal(input raster_e r);
        return (r == RASTER_WIDE) ? PRE_WIDE : PRE_NARROW;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= FP_COUNT;
            cnt_q <= '0;
            ras_q <= decode_raster(raster_sel);
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            ras_q <= ras_d;
        end
    end

    // Next-state logic
    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        ras_d = ras_q;
        unique case (ph_q)
            FP_COUNT: begin
                cnt_d = cnt_q + CNT_ONE;
                if (cnt_q == pre_terminal(ras_q)) begin
                    ph_d = FP_TERMINAL;
                end
            end
            FP_TERMINAL: begin
                cnt_d = '0;
                ras_d = decode_raster(raster_sel);
                ph_d  = FP_COUNT;
            end
        endcase
    end

    // Output logic
    always_comb begin
        tick = 1'b0;
        unique case (ph_q)
            FP_COUNT:    tick = 1'b0;
            FP_TERMINAL: tick = 1'b1;
        endcase
    end

endmodule

// File: rtl/refdiv_slow_stage.sv
module refdiv_slow_stage
    import refdiv_pkg::*;
#(
    parameter int unsigned SLOW_RATIO = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_tick,
    output logic slow_tick
);

    localparam int unsigned SL_W = (SLOW_RATIO > 2) ? $clog2(SLOW_RATIO) : 1;
    localparam logic [SL_W-1:0] PRE_LAST = SL_W'(SLOW_RATIO - 2);
    localparam logic [SL_W-1:0] SL_ONE   = SL_W'(1);

    slow_phase_e     ph_q,  ph_d;
    logic [SL_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= SP_GATHER;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic: advances only on fast ticks
    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        if (fast_tick) begin
            unique case (ph_q)
                SP_GATHER: begin
                    cnt_d = cnt_q + SL_ONE;
                    if (cnt_q == PRE_LAST) begin
                        ph_d = SP_FINAL;
                    end
                end
                SP_FINAL: begin
                    cnt_d = '0;
                    ph_d  = SP_GATHER;
                end
            endcase
        end
    end

    // Output logic: the slow tick rides on the closing fast tick
    always_comb begin
        slow_tick = 1'b0;
        unique case (ph_q)
            SP_GATHER: slow_tick = 1'b0;
            SP_FINAL:  slow_tick = fast_tick;
        endcase
    end

endmodule

// File: rtl/xtal_ref_divider.sv
module xtal_ref_divider #(
    parameter int unsigned DIV_NARROW = 125,
    parameter int unsigned DIV_WIDE   = 100,
    parameter int unsigned SLOW_RATIO = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic raster_sel,
    output logic ref_fast,
    output logic ref_slow
);

    logic fast_tick;

    refdiv_fast_stage #(
        .DIV_NARROW (DIV_NARROW),
        .DIV_WIDE   (DIV_WIDE)
    ) u_fast (
        .clk        (clk),
        .rst        (rst),
        .raster_sel (raster_sel),
        .tick       (fast_tick)
    );

    refdiv_slow_stage #(
        .SLOW_RATIO (SLOW_RATIO)
    ) u_slow (
        .clk        (clk),
        .rst        (rst),
        .fast_tick  (fast_tick),
        .slow_tick  (ref_slow)
    );

    assign ref_fast = fast_tick;

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
    parameter int unsigned DIV_NARROW = 125,
    parameter int unsigned DIV_WIDE   = 100,
    parameter int unsigned SLOW_RATIO = 32
) (
    input logic clk,
    input logic rst,
    input logic raster_sel,
    input logic ref_fast,
    input logic ref_slow
);

    logic        armed = 1'b0;
    int unsigned gap   = 0;
    int unsigned nfast = 0;

    // Cycles since reset or since the last fast tick, and fast ticks in the group.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            gap   <= 1;
            nfast <= 0;
        end else begin
            gap <= ref_fast ? 1 : gap + 1;
            if (ref_fast) begin
                nfast <= (nfast == SLOW_RATIO - 1) ? 0 : nfast + 1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ref_fast && !ref_slow)); // R1

    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (rst || !armed)
        ref_fast |-> (gap == DIV_NARROW || gap == DIV_WIDE)); // R2

    AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || !armed)
        ref_fast |=> !ref_fast); // R4

    AST_SLOW_INSIDE_FAST: assert property (@(posedge clk) disable iff (rst || !armed)
        ref_slow |-> ref_fast); // R5

    AST_SLOW_EVERY_GROUP: assert property (@(posedge clk) disable iff (rst || !armed)
        ref_fast |-> (ref_slow == (nfast == SLOW_RATIO - 1))); // R5

endmodule

bind xtal_ref_divider refdiv_checker #(
    .DIV_NARROW (DIV_NARROW),
    .DIV_WIDE   (DIV_WIDE),
    .SLOW_RATIO (SLOW_RATIO)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .raster_sel (raster_sel),
    .ref_fast   (ref_fast),
    .ref_slow   (ref_slow)
);

// File: tb/xtal_ref_divider_test.sv
`timescale 1ns/1ps
module xtal_ref_divider_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raster_sel = 1'b0;
    logic ref_fast, ref_slow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    xtal_ref_divider uut (
        .clk        (clk),
        .rst        (rst),
        .raster_sel (raster_sel),
        .ref_fast   (ref_fast),
        .ref_slow   (ref_slow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model, updated on each rising edge
    int  m_cnt = 0, m_ratio = 125, m_groups = 0;
    bit  m_valid = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt    = 0;
            m_ratio  = raster_sel ? 100 : 125;
            m_groups = 0;
            m_valid  = 1;
        end else if (m_valid) begin
            if (m_cnt == m_ratio - 1) begin
                m_cnt    = 0;
                m_ratio  = raster_sel ? 100 : 125;
                m_groups = (m_groups == 31) ? 0 : m_groups + 1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    bit prev_fast = 0;
    always @(negedge clk) begin
        if (m_valid && !done) begin
            bit ef, es;
            ef = (m_cnt == m_ratio - 1);
            es = ef && (m_groups == 31);
            check(ref_fast == ef, (m_ratio == 125) ? "R2 fast" : "R3 fast", ref_fast, ef);
            check(ref_slow == es, "R5 slow", ref_slow, es);
            check(!(prev_fast && ref_fast), "R4 width", ref_fast, 0);
            prev_fast = ref_fast;
        end
    end

    task automatic count_to_fast(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_fast);
    endtask

    task automatic count_to_slow(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_slow);
    endtask

    task automatic apply_reset(input logic sel, input int cyc);
        @(negedge clk);
        rst = 1'b1;
        raster_sel = sel;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            check(!ref_fast && !ref_slow, "R1 reset quiet", {ref_fast, ref_slow}, 0);
        end
        rst = 1'b0;
    endtask

    initial begin
        int n;
        apply_reset(1'b0, 3);
        count_to_fast(n);
        check(n == 124, "R7 first tick narrow", n, 124);

        for (int i = 0; i < 64; i++) begin
            count_to_fast(n);
            check(n == 125, "R2 period", n, 125);
        end

        count_to_slow(n);
        count_to_slow(n);
        check(n == 4000, "R8 slow spacing narrow", n, 4000);

        // Change raster mid-period
        count_to_fast(n);
        repeat (10) @(negedge clk);
        raster_sel = 1'b1;
        count_to_fast(n);
        check(n == 115, "R6 running period kept", n, 115);
        count_to_fast(n);
        check(n == 100, "R3 period", n, 100);

        // Glitch the select inside a period and back
        repeat (20) @(negedge clk);
        raster_sel = 1'b0;
        repeat (30) @(negedge clk);
        raster_sel = 1'b1;
        count_to_fast(n);
        check(n == 50, "R6 glitch remainder", n, 50);
        count_to_fast(n);
        check(n == 100, "R6 glitch ignored", n, 100);

        count_to_slow(n);
        count_to_slow(n);
        check(n == 3200, "R8 slow spacing wide", n, 3200);

        // Mid-run reset with wide raster, then narrow
        repeat (37) @(negedge clk);
        apply_reset(1'b1, 2);
        count_to_fast(n);
        check(n == 99, "R7 first tick wide", n, 99);
        count_to_slow(n);
        check(n == 31 * 100, "R5 first slow after reset", n, 3100);

        repeat (5) @(negedge clk);
        apply_reset(1'b0, 1);
        raster_sel = 1'b1;
        count_to_fast(n);
        check(n == 124, "R7 select sampled at reset", n, 124);
        count_to_fast(n);
        check(n == 100, "R3 after reset", n, 100);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule